// File: doc/BRIEF.md
# Flash Block Read Sequencer

This block is a bus master that pulls one complete erase block out of a NAND-style flash device whose control lives in memory-mapped 16-bit registers and whose page data sits in an internal buffer RAM. A requester pulses `start` with a block number. The sequencer then walks the block's pages in ascending order. For each page it programs the device's address and buffer-select registers, clears the interrupt register and issues the read command. It polls the interrupt register until the completion flag appears, then checks the controller status and, when the device reports a finished read, the ECC status. On the first two pages it also inspects the bad-block marker in the spare area. Only after all of these checks pass does it copy the page out of the data RAM as 32-bit words.

Each copied word leaves on a one-cycle output beat tagged with its byte offset inside the block. The run ends with a single-cycle `done` pulse. At that point `err` and a three-bit cause code tell whether the block arrived intact. If not, the code says why: controller fault, uncorrectable ECC, bad block, or no completion within the poll budget. Both register accesses and data-RAM reads use a request/ready handshake, and at most one access is in flight at any time.

Top module: `flash_blk_reader`

## Requirements
- R1: While and right after synchronous reset, `busy`, `done`, `err`, `reg_req`, `dat_req` and `out_valid` are all low.
- R2: For every page the register bus carries exactly six writes, in this order: start-address-1 ← block number, start-address-8 ← page number shifted left by 2, start-buffer ← 0x0800, start-address-2 ← 0, interrupt ← clear value, command ← read value.
- R3: A request holds its address, direction and write data steady until the ready input is sampled high, and the register and data requests are never high together.
- R4: After the command write, the interrupt register is read again and again until bit 15 (completion) reads 1. The next access is one read of the controller status register.
- R5: When bit 10 of the controller status reads 1, the run ends at once with `err`=1 and code 1. No further access or data beat follows.
- R6: The ECC status register is read only when bit 7 of the final interrupt poll value is 1. Any set bit under the uncorrectable mask (default 0x8888) ends the run with code 2.
- R7: On pages 0 and 1 only, the first spare halfword is read. Any value other than 0xFFFF ends the run with code 3 before that page's data moves.
- R8: Each page is moved as PAGE_BYTES/4 data reads at DATA_BASE+word in ascending order. Every read yields one `out_valid` beat with the word and byte offset page·PAGE_BYTES+word·4. Pages run from 0 to PAGES-1.
- R9: When POLL_LIMIT polls of one page in a row lack the completion bit, the run ends with code 4.
- R10: `done` is a one-cycle pulse. `err` and `err_code` (0 on success) hold until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin reading a block (taken when idle) |
| blk_num | input | BLK_W | Block to read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run failed |
| err_code | output | 3 | 0 ok, 1 controller, 2 ECC, 3 bad block, 4 poll timeout |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | AW | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, valid with reg_rdy |
| reg_rdy | input | 1 | Register access completes this cycle |
| dat_req | output | 1 | Data RAM word read request |
| dat_addr | output | DAW | Data RAM word address |
| dat_rdata | input | 32 | Data word, valid with dat_rdy |
| dat_rdy | input | 1 | Data read completes this cycle |
| out_valid | output | 1 | Output word beat |
| out_data | output | 32 | Output word |
| out_off | output | OFF_W | Byte offset of the word within the block |

## Verification
The bench builds the block with 64-byte pages, so each page takes 16 word reads. It keeps the full 64 pages per block and sets the poll budget to 8, so every page of a block, both spare-checked pages and the timeout path fit into a few thousand cycles. A non-zero read command value (0x00A5) makes the command write distinguishable from the zero-valued writes around it. Failure pages are drawn at random from the middle of the block, with directed cases for the two marker pages.

// File: rtl/flash_rd_pkg.sv
// Shared definitions for the flash block read sequencer: controller states
// and the completion cause codes reported to the requester.
package flash_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SA1,
        ST_SA8,
        ST_SBUF,
        ST_SA2,
        ST_ICLR,
        ST_CMD,
        ST_POLL,
        ST_CTRL,
        ST_ECC,
        ST_SPARE,
        ST_DATA
    } fr_state_e;

    typedef logic [2:0] fr_err_t;

    localparam fr_err_t FR_OK   = 3'd0;
    localparam fr_err_t FR_CTRL = 3'd1;
    localparam fr_err_t FR_ECC  = 3'd2;
    localparam fr_err_t FR_BAD  = 3'd3;
    localparam fr_err_t FR_TMO  = 3'd4;

endpackage

// File: rtl/flash_reg_step.sv
// Register-bus driver for one sequencer state. It decodes the current state
// into the request, direction, address and write data of the single register
// access that the state performs.
// Assumes BLK_W <= 16 and PG_W + 2 <= 16.
module flash_reg_step
    import flash_rd_pkg::*;
#(
    parameter int          AW           = 16,
    parameter int          BLK_W        = 16,
    parameter int          PG_W         = 6,
    parameter logic [AW-1:0] REG_SA1    = 16'hF100,
    parameter logic [AW-1:0] REG_SA2    = 16'hF101,
    parameter logic [AW-1:0] REG_SA8    = 16'hF107,
    parameter logic [AW-1:0] REG_SBUF   = 16'hF200,
    parameter logic [AW-1:0] REG_CMD    = 16'hF220,
    parameter logic [AW-1:0] REG_CTRL   = 16'hF240,
    parameter logic [AW-1:0] REG_INT    = 16'hF241,
    parameter logic [AW-1:0] REG_ECC    = 16'hFF00,
    parameter logic [AW-1:0] SPARE_ADDR = 16'h8200,
    parameter logic [15:0] BUF_SEL_VAL  = 16'h0800,
    parameter logic [15:0] INT_CLR_VAL  = 16'h0000,
    parameter logic [15:0] CMD_READ_VAL = 16'h0000
) (
    input  fr_state_e        st,
    input  logic [BLK_W-1:0] blk,
    input  logic [PG_W-1:0]  page,
    output logic             req,
    output logic             we,
    output logic [AW-1:0]    addr,
    output logic [15:0]      wdata
);

    // Map the state onto the access it owns.
    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        case (st)
            ST_SA1: begin
                we = 1'b1;
                addr = REG_SA1;
                wdata[BLK_W-1:0] = blk;
            end
            ST_SA8: begin
                we = 1'b1;
                addr = REG_SA8;
                wdata[PG_W+1:0] = {page, 2'b00};
            end
            ST_SBUF: begin
                we = 1'b1;
                addr = REG_SBUF;
                wdata = BUF_SEL_VAL;
            end
            ST_SA2: begin
                we = 1'b1;
                addr = REG_SA2;
            end
            ST_ICLR: begin
                we = 1'b1;
                addr = REG_INT;
                wdata = INT_CLR_VAL;
            end
            ST_CMD: begin
                we = 1'b1;
                addr = REG_CMD;
                wdata = CMD_READ_VAL;
            end
            ST_POLL:  addr = REG_INT;
            ST_CTRL:  addr = REG_CTRL;
            ST_ECC:   addr = REG_ECC;
            ST_SPARE: addr = SPARE_ADDR;
            default:  req = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_poll_timer.sv
// Counts interrupt polls that came back without the completion flag. It
// flags the poll that would be the LIMIT-th such miss, so the sequencer can
// give up on that access. The count clears while the command is issued.
// Assumes LIMIT >= 1.
module flash_poll_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Miss counter: cleared per page, advanced on each missed poll.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/flash_walk_ctr.sv
// Page and word position within the block being read. The word counter wraps
// at the end of a page, and the page counter steps when the sequencer moves
// on to the next page.
// Assumes WORDS and PAGES are powers of two, each at least 2.
module flash_walk_ctr #(
    parameter int PAGES = 64,
    parameter int WORDS = 512,
    localparam int PG_W = $clog2(PAGES),
    localparam int WD_W = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            word_inc,
    input  logic            page_inc,
    output logic [PG_W-1:0] page,
    output logic [WD_W-1:0] word,
    output logic            last_word,
    output logic            last_page
);

    // Word index inside the current page.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
        end else if (word_inc) begin
            word <= word + 1'b1;
        end
    end

    // Page index inside the block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            page <= '0;
        end else if (page_inc) begin
            page <= page + 1'b1;
        end
    end

    assign last_word = (word == WD_W'(WORDS - 1));
    assign last_page = (page == PG_W'(PAGES - 1));

endmodule

// File: rtl/flash_blk_reader.sv
// Top of the flash block read sequencer. It reads pages 0..PAGES-1 of one
// block. For each page it writes the address and command registers, polls
// for completion, and checks controller status, ECC status and (on pages 0
// and 1) the bad-block marker. Then it streams the page out of the device's
// data RAM as 32-bit words. Only one bus access is in flight at a time.
// Assumes the device holds reg_rdata/dat_rdata valid in the cycle its ready
// input is high, and PAGE_BYTES and PAGES are powers of two.
module flash_blk_reader
    import flash_rd_pkg::*;
#(
    parameter int          BLK_W        = 16,
    parameter int          AW           = 16,
    parameter int          DAW          = 16,
    parameter int          PAGES        = 64,
    parameter int          PAGE_BYTES   = 2048,
    parameter int          POLL_LIMIT   = 1024,
    parameter logic [AW-1:0] REG_SA1    = 16'hF100,
    parameter logic [AW-1:0] REG_SA2    = 16'hF101,
    parameter logic [AW-1:0] REG_SA8    = 16'hF107,
    parameter logic [AW-1:0] REG_SBUF   = 16'hF200,
    parameter logic [AW-1:0] REG_CMD    = 16'hF220,
    parameter logic [AW-1:0] REG_CTRL   = 16'hF240,
    parameter logic [AW-1:0] REG_INT    = 16'hF241,
    parameter logic [AW-1:0] REG_ECC    = 16'hFF00,
    parameter logic [AW-1:0] SPARE_ADDR = 16'h8200,
    parameter logic [DAW-1:0] DATA_BASE = 16'h0200,
    parameter logic [15:0] BUF_SEL_VAL  = 16'h0800,
    parameter logic [15:0] INT_CLR_VAL  = 16'h0000,
    parameter logic [15:0] CMD_READ_VAL = 16'h0000,
    parameter int          INT_DONE_BIT = 15,
    parameter int          INT_RD_BIT   = 7,
    parameter int          CTRL_ERR_BIT = 10,
    parameter logic [15:0] ECC_UNCORR_MASK = 16'h8888,
    localparam int WORDS = PAGE_BYTES / 4,
    localparam int PG_W  = $clog2(PAGES),
    localparam int WD_W  = $clog2(WORDS),
    localparam int OFF_W = PG_W + WD_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] blk_num,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [2:0]       err_code,
    output logic             reg_req,
    output logic             reg_we,
    output logic [AW-1:0]    reg_addr,
    output logic [15:0]      reg_wdata,
    input  logic [15:0]      reg_rdata,
    input  logic             reg_rdy,
    output logic             dat_req,
    output logic [DAW-1:0]   dat_addr,
    input  logic [31:0]      dat_rdata,
    input  logic             dat_rdy,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic [OFF_W-1:0] out_off
);

    fr_state_e        st;
    fr_state_e        chk_next;
    logic [BLK_W-1:0] blk_q;
    logic             int_rd;
    logic [PG_W-1:0]  page;
    logic [WD_W-1:0]  word;
    logic             last_word;
    logic             last_page;
    logic             w_clr;
    logic             w_word_inc;
    logic             w_page_inc;
    logic             t_clr;
    logic             t_tick;
    logic             t_last;
    logic             reg_ack;

    flash_reg_step #(
        .AW(AW), .BLK_W(BLK_W), .PG_W(PG_W),
        .REG_SA1(REG_SA1), .REG_SA2(REG_SA2), .REG_SA8(REG_SA8),
        .REG_SBUF(REG_SBUF), .REG_CMD(REG_CMD), .REG_CTRL(REG_CTRL),
        .REG_INT(REG_INT), .REG_ECC(REG_ECC), .SPARE_ADDR(SPARE_ADDR),
        .BUF_SEL_VAL(BUF_SEL_VAL), .INT_CLR_VAL(INT_CLR_VAL),
        .CMD_READ_VAL(CMD_READ_VAL)
    ) u_step (
        .st(st), .blk(blk_q), .page(page),
        .req(reg_req), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata)
    );

    flash_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .tick(t_tick), .last(t_last)
    );

    flash_walk_ctr #(.PAGES(PAGES), .WORDS(WORDS)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr(w_clr),
        .word_inc(w_word_inc), .page_inc(w_page_inc),
        .page(page), .word(word),
        .last_word(last_word), .last_page(last_page)
    );

    // Sub-block controls derived from the current state and handshakes.
    always_comb begin
        reg_ack    = reg_req && reg_rdy;
        w_clr      = (st == ST_IDLE) && start;
        w_word_inc = (st == ST_DATA) && dat_rdy;
        w_page_inc = w_word_inc && last_word && !last_page;
        t_clr      = (st == ST_CMD);
        t_tick     = (st == ST_POLL) && reg_rdy && !reg_rdata[INT_DONE_BIT];
        chk_next   = (page <= PG_W'(1)) ? ST_SPARE : ST_DATA;
    end

    assign busy     = (st != ST_IDLE);
    assign dat_req  = (st == ST_DATA);
    assign dat_addr = DATA_BASE + DAW'(word);

    // Sequencer: register program, poll, status checks, then the data copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            done      <= 1'b0;
            err       <= 1'b0;
            err_code  <= FR_OK;
            blk_q     <= '0;
            int_rd    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_off   <= '0;
        end else begin
            done      <= 1'b0;
            out_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        blk_q    <= blk_num;
                        err      <= 1'b0;
                        err_code <= FR_OK;
                        st       <= ST_SA1;
                    end
                end
                ST_SA1:  if (reg_ack) st <= ST_SA8;
                ST_SA8:  if (reg_ack) st <= ST_SBUF;
                ST_SBUF: if (reg_ack) st <= ST_SA2;
                ST_SA2:  if (reg_ack) st <= ST_ICLR;
                ST_ICLR: if (reg_ack) st <= ST_CMD;
                ST_CMD:  if (reg_ack) st <= ST_POLL;
                ST_POLL: begin
                    if (reg_ack) begin
                        if (reg_rdata[INT_DONE_BIT]) begin
                            int_rd <= reg_rdata[INT_RD_BIT];
                            st     <= ST_CTRL;
                        end else if (t_last) begin
                            st       <= ST_IDLE;
                            done     <= 1'b1;
                            err      <= 1'b1;
                            err_code <= FR_TMO;
                        end
                    end
                end
                ST_CTRL: begin
                    if (reg_ack) begin
                        if (reg_rdata[CTRL_ERR_BIT]) begin
                            st       <= ST_IDLE;
                            done     <= 1'b1;
                            err      <= 1'b1;
                            err_code <= FR_CTRL;
                        end else if (int_rd) begin
                            st <= ST_ECC;
                        end else begin
                            st <= chk_next;
                        end
                    end
                end
                ST_ECC: begin
                    if (reg_ack) begin
                        if (|(reg_rdata & ECC_UNCORR_MASK)) begin
                            st       <= ST_IDLE;
                            done     <= 1'b1;
                            err      <= 1'b1;
                            err_code <= FR_ECC;
                        end else begin
                            st <= chk_next;
                        end
                    end
                end
                ST_SPARE: begin
                    if (reg_ack) begin
                        if (reg_rdata != 16'hFFFF) begin
                            st       <= ST_IDLE;
                            done     <= 1'b1;
                            err      <= 1'b1;
                            err_code <= FR_BAD;
                        end else begin
                            st <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (dat_rdy) begin
                        out_valid <= 1'b1;
                        out_data  <= dat_rdata;
                        out_off   <= {page, word, 2'b00};
                        if (last_word) begin
                            if (last_page) begin
                                st   <= ST_IDLE;
                                done <= 1'b1;
                            end else begin
                                st <= ST_SA1;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_blk_reader_chk.sv
// Protocol checker for the flash block read sequencer, bound into every
// instance of the top. It watches only the block's ports.
module flash_blk_reader_chk
    import flash_rd_pkg::*;
#(
    parameter int            AW           = 16,
    parameter int            DAW          = 16,
    parameter logic [AW-1:0] REG_CMD      = 16'hF220,
    parameter logic [AW-1:0] REG_INT      = 16'hF241,
    parameter logic [AW-1:0] REG_CTRL     = 16'hF240,
    parameter int            CTRL_ERR_BIT = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           done,
    input logic           err,
    input logic [2:0]     err_code,
    input logic           reg_req,
    input logic           reg_we,
    input logic [AW-1:0]  reg_addr,
    input logic [15:0]    reg_wdata,
    input logic [15:0]    reg_rdata,
    input logic           reg_rdy,
    input logic           dat_req,
    input logic [DAW-1:0] dat_addr,
    input logic           dat_rdy
);

    a_r3_one_master: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && dat_req));

    a_r3_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_rdy |=> reg_req && $stable(reg_addr)
                                && $stable(reg_we) && $stable(reg_wdata));

    a_r8_dat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dat_req && !dat_rdy |=> dat_req && $stable(dat_addr));

    a_r4_poll_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && reg_rdy && reg_we && reg_addr == REG_CMD
        |=> reg_req && !reg_we && reg_addr == REG_INT);

    a_r5_ctrl_abort: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && reg_rdy && !reg_we && reg_addr == REG_CTRL
        && reg_rdata[CTRL_ERR_BIT]
        |=> done && err && err_code == FR_CTRL && !reg_req && !dat_req);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_ok_code: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err |-> err_code == FR_OK);

endmodule

bind flash_blk_reader flash_blk_reader_chk #(
    .AW(AW), .DAW(DAW), .REG_CMD(REG_CMD), .REG_INT(REG_INT),
    .REG_CTRL(REG_CTRL), .CTRL_ERR_BIT(CTRL_ERR_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .err(err), .err_code(err_code),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rdy(reg_rdy),
    .dat_req(dat_req), .dat_addr(dat_addr), .dat_rdy(dat_rdy)
);

// File: tb/flash_blk_reader_tb.sv
// Self-checking bench: a behavioural flash device with random handshake
// latency and random poll delays, scored against requirement-level models.
module flash_blk_reader_tb;

    localparam int PAGES      = 64;
    localparam int PAGE_BYTES = 64;
    localparam int WORDS      = PAGE_BYTES / 4;
    localparam int POLL_LIMIT = 8;
    localparam int OFF_W      = $clog2(PAGES) + $clog2(WORDS) + 2;
    localparam logic [15:0] A_SA1 = 16'hF100, A_SA2 = 16'hF101, A_SA8 = 16'hF107;
    localparam logic [15:0] A_SBUF = 16'hF200, A_CMD = 16'hF220, A_CTRL = 16'hF240;
    localparam logic [15:0] A_INT = 16'hF241, A_ECC = 16'hFF00, A_SPARE = 16'h8200;
    localparam logic [15:0] D_BASE = 16'h0200;
    localparam logic [15:0] V_CMD = 16'h00A5;

    logic clk = 0, rst_n = 0, start = 0;
    logic [15:0] blk_num = 0;
    logic busy, done, err;
    logic [2:0] err_code;
    logic reg_req, reg_we, reg_rdy = 0;
    logic [15:0] reg_addr, reg_wdata, reg_rdata = 0;
    logic dat_req, dat_rdy = 0;
    logic [15:0] dat_addr;
    logic [31:0] dat_rdata = 0;
    logic out_valid;
    logic [31:0] out_data;
    logic [OFF_W-1:0] out_off;

    flash_blk_reader #(
        .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .POLL_LIMIT(POLL_LIMIT),
        .CMD_READ_VAL(V_CMD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_num(blk_num),
        .busy(busy), .done(done), .err(err), .err_code(err_code),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rdy(reg_rdy),
        .dat_req(dat_req), .dat_addr(dat_addr), .dat_rdata(dat_rdata),
        .dat_rdy(dat_rdy), .out_valid(out_valid), .out_data(out_data),
        .out_off(out_off)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    // Run configuration and device-side tallies.
    int cfg_blk, cfg_kind, cfg_fpage, cfg_rbit;
    int pg, widx, poll_in_pg, poll_fail_n, exp_polls;
    int polls, ctrl_reads, ecc_reads, spare_reads, writes;
    int wr_err, rd_err, hold_err, dat_err, out_err, out_cnt, exp_word;
    int reg_wait = 0, dat_wait = 0;
    bit reg_pend = 0, dat_pend = 0;
    logic [15:0] p_addr, p_wd;
    logic p_we;
    logic [15:0] p_daddr;

    function automatic logic [31:0] word_val(int b, int p, int w);
        return {b[15:0] ^ 16'hC3C3, 16'(p * 37 + w * 5 + 1)};
    endfunction

    function automatic logic [15:0] exp_waddr(int k);
        case (k)
            0: return A_SA1;
            1: return A_SA8;
            2: return A_SBUF;
            3: return A_SA2;
            4: return A_INT;
            default: return A_CMD;
        endcase
    endfunction

    function automatic logic [15:0] exp_wdata(int k, int p, int b);
        case (k)
            0: return b[15:0];
            1: return 16'(p << 2);
            2: return 16'h0800;
            3: return 16'h0000;
            4: return 16'h0000;
            default: return V_CMD;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Output scoreboard and behavioural flash device, evaluated at negedge.
    always @(negedge clk) begin
        if (out_valid) begin
            if (out_data != word_val(cfg_blk, out_cnt / WORDS, out_cnt % WORDS)
                || int'(out_off) != out_cnt * 4)
                out_err++;
            out_cnt++;
        end
        if (reg_req && dat_req) hold_err++;
        // register side
        if (reg_rdy) begin
            reg_rdy = 0;
            reg_pend = 0;
            reg_wait = $urandom_range(0, 2);
        end else begin
            if (reg_pend && (!reg_req || reg_addr != p_addr
                             || reg_we != p_we || reg_wdata != p_wd))
                hold_err++;
            if (reg_req) begin
                if (!reg_pend) begin
                    p_addr = reg_addr; p_we = reg_we; p_wd = reg_wdata;
                    reg_pend = 1;
                end
                if (reg_wait == 0) begin
                    reg_rdy = 1;
                    if (reg_we) begin
                        if (reg_addr == A_SA1) begin
                            pg++;
                            widx = 0;
                            poll_in_pg = 0;
                            poll_fail_n = $urandom_range(0, 3);
                            if (cfg_kind == 4 && pg == cfg_fpage) exp_polls += POLL_LIMIT;
                            else exp_polls += poll_fail_n + 1;
                        end
                        if (widx > 5 || reg_addr != exp_waddr(widx)
                            || reg_wdata != exp_wdata(widx, pg, cfg_blk))
                            wr_err++;
                        widx++;
                        writes++;
                    end else begin
                        if (widx != 6) rd_err++;
                        if (reg_addr == A_INT) begin
                            polls++;
                            poll_in_pg++;
                            if ((cfg_kind == 4 && pg == cfg_fpage) || poll_in_pg <= poll_fail_n)
                                reg_rdata = 16'($urandom) & 16'h7FFF;
                            else
                                reg_rdata = 16'h8000 | (cfg_rbit != 0 ? 16'h0080 : 16'h0000)
                                          | (16'($urandom) & 16'h7F7F);
                        end else if (reg_addr == A_CTRL) begin
                            ctrl_reads++;
                            reg_rdata = (cfg_kind == 1 && pg == cfg_fpage) ? 16'h0400
                                      : (16'($urandom) & 16'hFBFF);
                        end else if (reg_addr == A_ECC) begin
                            ecc_reads++;
                            reg_rdata = (cfg_kind == 2 && pg == cfg_fpage) ? 16'h0800
                                      : (16'($urandom) & 16'h7777);
                        end else if (reg_addr == A_SPARE) begin
                            spare_reads++;
                            reg_rdata = (cfg_kind == 3 && pg == cfg_fpage) ? 16'hFF00 : 16'hFFFF;
                        end else begin
                            rd_err++;
                        end
                    end
                end else begin
                    reg_wait--;
                end
            end
        end
        // data side
        if (dat_rdy) begin
            dat_rdy = 0;
            dat_pend = 0;
            dat_wait = $urandom_range(0, 2);
        end else begin
            if (dat_pend && (!dat_req || dat_addr != p_daddr)) hold_err++;
            if (dat_req) begin
                if (!dat_pend) begin
                    p_daddr = dat_addr;
                    dat_pend = 1;
                end
                if (dat_wait == 0) begin
                    dat_rdy = 1;
                    if (int'(dat_addr - D_BASE) != exp_word) dat_err++;
                    dat_rdata = word_val(cfg_blk, pg, int'(dat_addr - D_BASE));
                    exp_word = (exp_word + 1) % WORDS;
                end else begin
                    dat_wait--;
                end
            end
        end
    end

    // Run one block read and check the cause code, the R10 hold and protocol.
    task automatic run_block(int blk, int kind, int fpage, int rbit, int exp_code, string req);
        int cyc;
        cfg_blk = blk; cfg_kind = kind; cfg_fpage = fpage; cfg_rbit = rbit;
        pg = -1; widx = 6; exp_polls = 0; polls = 0; ctrl_reads = 0;
        ecc_reads = 0; spare_reads = 0; writes = 0; wr_err = 0; rd_err = 0;
        hold_err = 0; dat_err = 0; out_err = 0; out_cnt = 0; exp_word = 0;
        @(negedge clk);
        blk_num = 16'(blk);
        start = 1;
        @(negedge clk);
        start = 0;
        cyc = 0;
        while (!done && cyc < 40000) begin
            @(negedge clk);
            cyc++;
        end
        chk(req, "run reached done (watchdog)", int'(done), 1);
        chk(req, "err_code", int'(err_code), exp_code);
        chk(req, "err flag", int'(err), int'(exp_code != 0));
        @(negedge clk);
        chk("R10", "done is one cycle and code held", int'({done, err_code}), exp_code);
        chk("R3", "request hold and exclusivity", hold_err, 0);
        chk("R8", "data reads in order / output beats", dat_err + out_err, 0);
        chk("R2", "register write order and values", wr_err + rd_err, 0);
        chk("R4", "poll count", polls, exp_polls);
    endtask

    initial begin
        int fp;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk("R1", "idle outputs in reset", int'({busy, done, err, reg_req, dat_req, out_valid}), 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "idle outputs after reset", int'({busy, done, err, reg_req, dat_req, out_valid}), 0);

        // full successful block with read bit set
        run_block(int'($urandom & 16'hFFFF), 0, 0, 1, 0, "R10");
        chk("R8", "words delivered", out_cnt, PAGES * WORDS);
        chk("R2", "writes per block", writes, PAGES * 6);
        chk("R4", "controller status reads", ctrl_reads, PAGES);
        chk("R6", "ECC reads when read bit set", ecc_reads, PAGES);
        chk("R7", "marker reads only on pages 0 and 1", spare_reads, 2);

        // read bit clear: ECC status skipped
        run_block(int'($urandom & 16'hFFFF), 0, 0, 0, 0, "R6");
        chk("R6", "no ECC reads when read bit clear", ecc_reads, 0);
        chk("R8", "words delivered, read bit clear", out_cnt, PAGES * WORDS);

        // controller error
        fp = $urandom_range(2, 62);
        run_block(int'($urandom & 16'hFFFF), 1, fp, 1, 1, "R5");
        chk("R5", "words before controller error", out_cnt, fp * WORDS);
        chk("R5", "writes before controller error", writes, (fp + 1) * 6);
        chk("R5", "ECC reads before controller error", ecc_reads, fp);

        // uncorrectable ECC
        fp = $urandom_range(2, 62);
        run_block(int'($urandom & 16'hFFFF), 2, fp, 1, 2, "R6");
        chk("R6", "words before ECC failure", out_cnt, fp * WORDS);

        // bad-block marker on page 1, then page 0
        run_block(16'h0007, 3, 1, 1, 3, "R7");
        chk("R7", "words before bad marker on page 1", out_cnt, WORDS);
        run_block(16'h0008, 3, 0, 1, 3, "R7");
        chk("R7", "words before bad marker on page 0", out_cnt, 0);
        chk("R7", "marker reads with page 0 bad", spare_reads, 1);

        // poll timeout
        fp = $urandom_range(1, 62);
        run_block(int'($urandom & 16'hFFFF), 4, fp, 1, 4, "R9");
        chk("R9", "words before poll timeout", out_cnt, fp * WORDS);
        chk("R9", "polls including POLL_LIMIT misses", polls, exp_polls);

        // fresh start clears the previous failure
        run_block(16'hFFFF, 0, 0, 1, 0, "R10");
        chk("R10", "words after a failed run", out_cnt, PAGES * WORDS);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Global watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule